// File: doc/BRIEF.md
# Serial Byte Double Buffer

This block sits between a serial bit engine for a two-wire bus and a host. Each direction has a shift register that faces the engine and a holding register that faces the host. The block moves bytes between the two registers in each direction. It also reports when the host has fallen behind: a receive overrun when it has not read in time, and a transmit underflow when it has not written in time.

On the receive side, the engine presents one bit per strobe, most significant bit first. A byte-complete flag comes with the eighth bit. If the holding register still holds an unread byte at that point, the completed byte stays in the shift register and an overrun is raised. Bits that arrive later keep shifting in and overwrite it. The waiting shift register contents are moved to the holding register in the same cycle as the host read that frees it.

On the transmit side, the engine requests a load before each byte and shifts bits out with a strobe. If the host has written nothing since the last transfer, the block does not stall. It sends the previous byte again and drops its not-empty indicator to flag the underflow.

Top module: `serial_byte_buffer`

## Requirements
- R1: After reset, rx_ready and rx_overrun are 0, rx_data is 0, and tx_ready and tx_not_empty are both 1.
- R2: Received bits enter the shift register most significant bit first. When rx_bit_vld and rx_byte_done are both high and the holding register is empty, the completed byte appears on rx_data and rx_ready is 1 in the next cycle.
- R3: A host_rd pulse while rx_ready is 1 and no overrun is pending drops rx_ready in the next cycle.
- R4: When a byte completes while rx_ready is 1 and host_rd is low, rx_overrun rises in the next cycle and rx_data keeps the unread byte.
- R5: A host_rd pulse during an overrun copies the current shift register contents, including any later bits that overwrote the completed byte, into rx_data. This is visible in the next cycle, together with rx_overrun at 0 and rx_ready staying at 1.
- R6: dbg_peek pulses do not change rx_overrun, rx_ready or rx_data.
- R7: A host_wr pulse without a load request drops tx_ready in the next cycle, and tx_not_empty is 1 after it.
- R8: A tx_load_req moves freshly written data into the transmit shift register and raises tx_ready. tx_bit then shows the byte most significant bit first, advancing one bit per tx_shift pulse.
- R9: A tx_load_req with no host write since the last transfer drops tx_not_empty to 0 and loads the previous byte again for retransmission.
- R10: Any host_wr sets tx_not_empty to 1 in the next cycle.
- R11: A host_wr in the same cycle as tx_load_req loads the written byte straight into the shift register. tx_ready stays 1 and tx_not_empty becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_vld | input | 1 | Engine presents one received bit |
| rx_bit | input | 1 | Received bit value |
| rx_byte_done | input | 1 | Marks the bit as the last of its byte |
| host_rd | input | 1 | Host read strobe for the receive holding register |
| dbg_peek | input | 1 | Debug-port read, no side effects |
| rx_data | output | DATA_W | Receive holding register |
| rx_ready | output | 1 | Holding register holds an unread byte |
| rx_overrun | output | 1 | Completed byte waits behind an unread one |
| host_wr | input | 1 | Host write strobe for the transmit holding register |
| host_wdata | input | DATA_W | Byte written by the host |
| tx_ready | output | 1 | Transmit holding register free to be written |
| tx_load_req | input | 1 | Engine requests the next byte into the shift register |
| tx_shift | input | 1 | Engine consumed one bit |
| tx_bit | output | 1 | Current outgoing bit |
| tx_not_empty | output | 1 | Low after an underflow, high after any write |

## Verification
The embedded properties check on every cycle that an overrun is only flagged while the holding register is full, that the holding register stays put until a read, and that a debug peek never clears the overrun. They also check that any write sets the not-empty indicator and that a stale load clears it. Only the bench scenarios can show the values involved: bit order in both directions, the exact byte taken from a shift register that was partly overwritten during an overrun, and the resend of the previous transmit byte.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  // Outcome of an engine load request in the transmit path
  typedef enum logic [1:0] {
    LD_IDLE,    // no request this cycle
    LD_FRESH,   // holding register written since last transfer
    LD_BYPASS,  // host write lands in the same cycle as the request
    LD_RESEND   // nothing new: previous byte goes out again
  } tx_load_e;
endpackage

// File: rtl/sbb_rx.sv
module sbb_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_vld,
  input  logic         bit_in,
  input  logic         byte_done,
  input  logic         host_rd,
  input  logic         dbg_peek,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         overrun
);
  logic [W-1:0] sr;
  logic [W-1:0] sr_nxt;
  logic         done;

  assign sr_nxt = bit_vld ? {sr[W-2:0], bit_in} : sr;
  assign done   = bit_vld & byte_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      rd_data <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      sr <= sr_nxt;
      if (overrun) begin
        // pending byte (possibly overwritten) moves on the freeing read
        if (host_rd) begin
          rd_data <= sr_nxt;
          overrun <= 1'b0;
        end
      end else if (done) begin
        if (!full || host_rd) begin
          rd_data <= sr_nxt;
          full    <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end else if (host_rd) begin
        full <= 1'b0;
      end
    end
  end

  p_ovr_needs_full_r4: assert property (@(posedge clk) disable iff (rst)
    overrun |-> full);
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (full && !host_rd) |=> $stable(rd_data));
  p_peek_keeps_ovr_r6: assert property (@(posedge clk) disable iff (rst)
    (dbg_peek && overrun && !host_rd) |=> overrun);
  p_read_clears_ovr_r5: assert property (@(posedge clk) disable iff (rst)
    (overrun && host_rd) |=> (!overrun && full));
endmodule

// File: rtl/sbb_tx.sv
module sbb_tx
  import sbb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  input  logic         shift,
  output logic         bit_out,
  output logic         ready,
  output logic         not_empty
);
  logic [W-1:0] hold;
  logic [W-1:0] sr;
  logic         fresh;
  tx_load_e     ld;

  always_comb begin
    ld = LD_IDLE;
    if (load) begin
      if (wr)         ld = LD_BYPASS;
      else if (fresh) ld = LD_FRESH;
      else            ld = LD_RESEND;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      sr        <= '0;
      fresh     <= 1'b0;
      not_empty <= 1'b1;
    end else begin
      if (wr) hold <= wdata;
      unique case (ld)
        LD_BYPASS: begin
          sr        <= wdata;
          fresh     <= 1'b0;
          not_empty <= 1'b1;
        end
        LD_FRESH: begin
          sr    <= hold;
          fresh <= 1'b0;
        end
        LD_RESEND: begin
          sr        <= hold;
          not_empty <= 1'b0;
        end
        default: begin
          if (shift) sr <= {sr[W-2:0], 1'b0};
          if (wr) begin
            fresh     <= 1'b1;
            not_empty <= 1'b1;
          end
        end
      endcase
    end
  end

  assign ready   = ~fresh;
  assign bit_out = sr[W-1];

  p_stale_load_r9: assert property (@(posedge clk) disable iff (rst)
    (load && !wr && ready) |=> !not_empty);
  p_write_sets_r10: assert property (@(posedge clk) disable iff (rst)
    wr |=> not_empty);
  p_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && !load) |=> !ready);
  p_load_frees_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> ready);
endmodule

// File: rtl/serial_byte_buffer.sv
module serial_byte_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              rx_byte_done,
  input  logic              host_rd,
  input  logic              dbg_peek,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overrun,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              tx_ready,
  input  logic              tx_load_req,
  input  logic              tx_shift,
  output logic              tx_bit,
  output logic              tx_not_empty
);
  localparam int W = DATA_W;

  sbb_rx #(.W(W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (rx_bit_vld),
    .bit_in    (rx_bit),
    .byte_done (rx_byte_done),
    .host_rd   (host_rd),
    .dbg_peek  (dbg_peek),
    .rd_data   (rx_data),
    .full      (rx_ready),
    .overrun   (rx_overrun)
  );

  sbb_tx #(.W(W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .wr        (host_wr),
    .wdata     (host_wdata),
    .load      (tx_load_req),
    .shift     (tx_shift),
    .bit_out   (tx_bit),
    .ready     (tx_ready),
    .not_empty (tx_not_empty)
  );
endmodule

// File: tb/serial_byte_buffer_bench.sv
`timescale 1ns/1ps
module serial_byte_buffer_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit_vld = 0, rx_bit = 0, rx_byte_done = 0, host_rd = 0, dbg_peek = 0;
  logic host_wr = 0, tx_load_req = 0, tx_shift = 0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] rx_data;
  logic rx_ready, rx_overrun, tx_ready, tx_bit, tx_not_empty;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  serial_byte_buffer #(.DATA_W(W)) u_serial_byte_buffer (.*);

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    rx_bit_vld = 0; rx_byte_done = 0; host_rd = 0; dbg_peek = 0;
    host_wr = 0; tx_load_req = 0; tx_shift = 0;
  endtask

  task automatic send_bits(input logic [W-1:0] b, input int n, input bit last);
    for (int i = n - 1; i >= 0; i--) begin
      rx_bit_vld = 1; rx_bit = b[i]; rx_byte_done = last && (i == 0);
      tick();
    end
  endtask

  task automatic do_read();  host_rd = 1; tick(); endtask
  task automatic do_write(input logic [W-1:0] d); host_wr = 1; host_wdata = d; tick(); endtask
  task automatic do_load();  tx_load_req = 1; tick(); endtask

  task automatic shift_out(input string req, input logic [W-1:0] b);
    for (int i = W - 1; i >= 0; i--) begin
      check(req, tx_bit, b[i]);
      tx_shift = 1; tick();
    end
  endtask

  task automatic t_reset();
    check("R1 rx_ready", rx_ready, 0);
    check("R1 rx_overrun", rx_overrun, 0);
    check("R1 rx_data", rx_data, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 tx_not_empty", tx_not_empty, 1);
  endtask

  task automatic t_rx_basic();
    send_bits(8'hA5, 8, 1);
    check("R2 data", rx_data, 8'hA5);
    check("R2 ready", rx_ready, 1);
    do_read();
    check("R3 ready clear", rx_ready, 0);
    send_bits(8'h5A, 8, 1);
    check("R2 data 2", rx_data, 8'h5A);
    do_read();
    check("R3 ready clear 2", rx_ready, 0);
  endtask

  task automatic t_rx_overrun();
    send_bits(8'h3C, 8, 1);
    send_bits(8'hC3, 8, 1);
    check("R4 overrun", rx_overrun, 1);
    check("R4 data kept", rx_data, 8'h3C);
    dbg_peek = 1; tick();
    dbg_peek = 1; tick();
    check("R6 overrun kept", rx_overrun, 1);
    check("R6 ready kept", rx_ready, 1);
    check("R6 data kept", rx_data, 8'h3C);
    do_read();
    check("R5 data moved", rx_data, 8'hC3);
    check("R5 overrun clear", rx_overrun, 0);
    check("R5 ready stays", rx_ready, 1);
    do_read();
    check("R3 ready clear", rx_ready, 0);
  endtask

  task automatic t_rx_overwrite();
    send_bits(8'hA5, 8, 1);
    send_bits(8'h3C, 8, 1);
    send_bits(8'h0F, 4, 0);
    check("R5 overrun during overwrite", rx_overrun, 1);
    do_read();
    check("R5 overwritten byte", rx_data, 8'hCF);
    check("R5 overrun clear", rx_overrun, 0);
    do_read();
  endtask

  task automatic t_tx_basic();
    do_write(8'h96);
    check("R7 tx_ready low", tx_ready, 0);
    check("R7 not_empty", tx_not_empty, 1);
    do_load();
    check("R8 tx_ready high", tx_ready, 1);
    shift_out("R8 bit", 8'h96);
  endtask

  task automatic t_tx_underflow();
    do_load();
    check("R9 not_empty low", tx_not_empty, 0);
    shift_out("R9 resend bit", 8'h96);
    do_write(8'h71);
    check("R10 not_empty set", tx_not_empty, 1);
    check("R7 tx_ready low", tx_ready, 0);
    do_load();
    shift_out("R8 bit 2", 8'h71);
  endtask

  task automatic t_tx_bypass();
    do_load();
    check("R9 not_empty low", tx_not_empty, 0);
    host_wr = 1; host_wdata = 8'hE8; tx_load_req = 1; tick();
    check("R11 not_empty", tx_not_empty, 1);
    check("R11 tx_ready", tx_ready, 1);
    shift_out("R11 bit", 8'hE8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_rx_basic();
    t_rx_overrun();
    t_rx_overwrite();
    t_tx_basic();
    t_tx_underflow();
    t_tx_bypass();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #100000;
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule